// File: doc/BRIEF.md
# Strobe Delay Tap Calibration Sweeper

This block calibrates the data-strobe delay used to capture read data from external DRAM. A single start pulse launches a sweep that moves a delay tap upward from zero to the largest legal setting. For each setting, the block writes the tap into the per-byte-lane delay registers and asks an external memory checker to run a self-test. It then waits for the checker to report completion and samples how many errors were seen.

Taps that produce zero errors are taken to form one unbroken passing window. The block remembers the first and the last passing tap. When the sweep ends it loads the rounded-up centre of that window into the lanes. If no tap passed, it loads a fixed fallback tap instead. A width input chooses a 16-bit interface, which uses two lanes, or a 32-bit interface, which uses four.

A build option targets delay lines made of two chained segments. In that option a large tap is split into a low field and a high field before it is written.

Top module: `dqs_tap_sweep`

## Requirements
- R1: After a start pulse, the block tests every tap from 0 up to TAP_MAX inclusive (63 by default, 62 in the split variant), in ascending order, with exactly one self-test per tap.
- R2: Before each test, and again for the final result, the tap code is written into lanes 0 and 1. Lanes 2 and 3 are written only when `wide` was 1 (32-bit) at the start pulse. When `wide` was 0, lanes 2 and 3 keep their previous contents.
- R3: `test_req` goes high after the tap is programmed and stays high until `test_done` is seen. The failure count is sampled in the cycle where `test_done` is high, and `test_req` is low in the following cycle.
- R4: `test_loops` always shows 8, the number of self-test iterations to run for each tap.
- R5: A tap passes only when its sampled failure count is zero. The result tap is (low + high + 1) / 2, where low is the first passing tap and high is the last passing tap.
- R6: If no tap passes, the result tap is 8 and `cal_found` stays 0.
- R7: In the split variant (SPLIT_CHAIN=1, TAP_MAX=62, half = 31), a tap greater than 31 is written as a 10-bit code. Bits [9:5] hold tap − 31 and bits [4:0] hold tap mod 32. A tap of 31 or less is written unchanged. In the default variant, each lane holds the 6-bit tap directly.
- R8: `cal_done` is high for exactly one cycle, in the cycle after the final code is written into the lanes. `cal_found` is 1 if any tap passed and holds its value until the next start.
- R9: After reset, `test_req`, `cal_done` and `cal_found` are 0 and every lane holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a calibration sweep |
| wide | input | 1 | 1 = 32-bit interface (four lanes), 0 = 16-bit interface (two lanes); sampled at start |
| test_req | output | 1 | Request to the memory checker to run the self-test at the current tap |
| test_loops | output | LOOP_W (4) | Self-test iterations per tap |
| test_done | input | 1 | Checker signals that the test is complete |
| test_fail_cnt | input | FAIL_W (8) | Checker failure count, valid while test_done is high |
| lane_taps | output | LANES*LANE_W (24) | Packed per-lane delay codes, lane 0 in the low bits |
| cal_done | output | 1 | One-cycle pulse when the result has been written |
| cal_found | output | 1 | At least one tap passed in the last sweep |
| cal_tap | output | TAP_W (6) | Chosen result tap |

## Verification
Lane preservation is hard to reach from the ports, because it can only be seen across two sweeps. The first sweep runs in 32-bit mode and fills all four lanes. A second sweep then runs in 16-bit mode with a different passing window, and the bench shows that lanes 2 and 3 still hold the first result while lanes 0 and 1 hold the new one.

The split encoding is also hard to reach, because it needs a window whose centre lands exactly on either side of the half point. The bench sets the checker model's windows to 30–32 and 30–33 so that the centre falls on 31 and on 32.

// File: rtl/dqs_sweep_pkg.sv
package dqs_sweep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROGRAM,
        ST_TEST,
        ST_RELEASE,
        ST_FINISH,
        ST_REPORT
    } sweep_state_e;

    // Centre of the passing window, rounded upward.
    function automatic int unsigned centre_tap(input int unsigned lo, input int unsigned hi);
        return (lo + hi + 1) / 2;
    endfunction

    // Two-segment code: upper field carries the excess over half, lower field the tap modulo 2**seg_w.
    function automatic int unsigned split_code(input int unsigned tap,
                                               input int unsigned half,
                                               input int unsigned seg_w);
        int unsigned low_mask;
        low_mask = (32'd1 << seg_w) - 32'd1;
        if (tap > half)
            return ((tap - half) << seg_w) | (tap & low_mask);
        return tap;
    endfunction

endpackage

// File: rtl/dqs_lane_encode.sv
module dqs_lane_encode
    import dqs_sweep_pkg::*;
#(
    parameter int TAP_MAX     = 63,
    parameter int SPLIT_CHAIN = 0,
    parameter int TAP_W       = 6,
    parameter int LANE_W      = 6
) (
    input  logic [TAP_W-1:0]  tap,
    output logic [LANE_W-1:0] code
);

    generate
        if (SPLIT_CHAIN != 0) begin : g_split
            localparam int HALF  = TAP_MAX / 2;
            localparam int SEG_W = $clog2(HALF + 1);
            assign code = LANE_W'(split_code(32'(tap), 32'(HALF), 32'(SEG_W)));
        end else begin : g_direct
            assign code = LANE_W'(tap);
        end
    endgenerate

endmodule

// File: rtl/dqs_pass_window.sv
module dqs_pass_window
    import dqs_sweep_pkg::*;
#(
    parameter int TAP_W       = 6,
    parameter int DEFAULT_TAP = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             upd,
    input  logic             pass,
    input  logic [TAP_W-1:0] tap,
    output logic             found,
    output logic [TAP_W-1:0] final_tap
);

    logic [TAP_W-1:0] lo_q;
    logic [TAP_W-1:0] hi_q;
    logic             found_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            found_q <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else if (upd && pass) begin
            if (!found_q) begin
                found_q <= 1'b1;
                lo_q    <= tap;
            end
            hi_q <= tap;
        end
    end

    assign found     = found_q;
    assign final_tap = found_q ? TAP_W'(centre_tap(32'(lo_q), 32'(hi_q)))
                               : TAP_W'(DEFAULT_TAP);

    // R5
    window_order_chk: assert property (@(posedge clk) disable iff (rst)
        found_q |-> (lo_q <= hi_q));

    // R5
    window_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (found_q && !clear) |=> $stable(lo_q));

endmodule

// File: rtl/dqs_lane_bank.sv
module dqs_lane_bank #(
    parameter int LANES        = 4,
    parameter int NARROW_LANES = 2,
    parameter int LANE_W       = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    wide,
    input  logic [LANE_W-1:0]       code,
    output logic [LANES*LANE_W-1:0] lanes
);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            localparam bit ALWAYS_ON = (g < NARROW_LANES);
            logic [LANE_W-1:0] lane_q;

            always_ff @(posedge clk) begin
                if (rst)
                    lane_q <= '0;
                else if (load && (ALWAYS_ON || wide))
                    lane_q <= code;
            end

            assign lanes[g*LANE_W +: LANE_W] = lane_q;

            if (!ALWAYS_ON) begin : g_upper
                // R2
                narrow_hold_chk: assert property (@(posedge clk) disable iff (rst)
                    (load && !wide) |=> $stable(lane_q));
            end
        end
    endgenerate

endmodule

// File: rtl/dqs_tap_sweep.sv
module dqs_tap_sweep
    import dqs_sweep_pkg::*;
#(
    parameter int TAP_MAX      = 63,
    parameter int SPLIT_CHAIN  = 0,
    parameter int DEFAULT_TAP  = 8,
    parameter int TEST_LOOPS   = 8,
    parameter int LOOP_W       = 4,
    parameter int FAIL_W       = 8,
    parameter int LANES        = 4,
    parameter int NARROW_LANES = 2,
    localparam int TAP_W  = $clog2(TAP_MAX + 1),
    localparam int HALF   = TAP_MAX / 2,
    localparam int SEG_W  = $clog2(HALF + 1),
    localparam int LANE_W = (SPLIT_CHAIN != 0) ? 2 * SEG_W : TAP_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    wide,
    output logic                    test_req,
    output logic [LOOP_W-1:0]       test_loops,
    input  logic                    test_done,
    input  logic [FAIL_W-1:0]       test_fail_cnt,
    output logic [LANES*LANE_W-1:0] lane_taps,
    output logic                    cal_done,
    output logic                    cal_found,
    output logic [TAP_W-1:0]        cal_tap
);

    sweep_state_e      state_q;
    logic [TAP_W-1:0]  tap_q;
    logic              wide_q;
    logic [FAIL_W-1:0] fail_q;

    logic [TAP_W-1:0]  final_tap;
    logic [TAP_W-1:0]  code_tap;
    logic [LANE_W-1:0] code;
    logic              win_clear;
    logic              lane_load;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tap_q   <= '0;
            wide_q  <= 1'b0;
            fail_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        tap_q   <= '0;
                        wide_q  <= wide;
                        state_q <= ST_PROGRAM;
                    end
                end
                ST_PROGRAM: state_q <= ST_TEST;
                ST_TEST: begin
                    if (test_done) begin
                        fail_q  <= test_fail_cnt;
                        state_q <= ST_RELEASE;
                    end
                end
                ST_RELEASE: begin
                    if (tap_q == TAP_W'(TAP_MAX)) begin
                        state_q <= ST_FINISH;
                    end else begin
                        tap_q   <= tap_q + 1'b1;
                        state_q <= ST_PROGRAM;
                    end
                end
                ST_FINISH: state_q <= ST_REPORT;
                ST_REPORT: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign win_clear = (state_q == ST_IDLE) && start;
    assign lane_load = (state_q == ST_PROGRAM) || (state_q == ST_FINISH);
    assign code_tap  = (state_q == ST_FINISH) ? final_tap : tap_q;

    dqs_pass_window #(
        .TAP_W       (TAP_W),
        .DEFAULT_TAP (DEFAULT_TAP)
    ) u_window (
        .clk       (clk),
        .rst       (rst),
        .clear     (win_clear),
        .upd       (state_q == ST_RELEASE),
        .pass      (fail_q == '0),
        .tap       (tap_q),
        .found     (cal_found),
        .final_tap (final_tap)
    );

    dqs_lane_encode #(
        .TAP_MAX     (TAP_MAX),
        .SPLIT_CHAIN (SPLIT_CHAIN),
        .TAP_W       (TAP_W),
        .LANE_W      (LANE_W)
    ) u_encode (
        .tap  (code_tap),
        .code (code)
    );

    dqs_lane_bank #(
        .LANES        (LANES),
        .NARROW_LANES (NARROW_LANES),
        .LANE_W       (LANE_W)
    ) u_lanes (
        .clk   (clk),
        .rst   (rst),
        .load  (lane_load),
        .wide  (wide_q),
        .code  (code),
        .lanes (lane_taps)
    );

    assign test_req   = (state_q == ST_TEST);
    assign test_loops = LOOP_W'(TEST_LOOPS);
    assign cal_done   = (state_q == ST_REPORT);
    assign cal_tap    = final_tap;

    // R3
    req_release_chk: assert property (@(posedge clk) disable iff (rst)
        (test_req && test_done) |=> !test_req);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> !cal_done);

    // R6
    fallback_tap_chk: assert property (@(posedge clk) disable iff (rst)
        (cal_done && !cal_found) |-> (cal_tap == TAP_W'(DEFAULT_TAP)));

    // R1
    sweep_end_chk: assert property (@(posedge clk) disable iff (rst)
        cal_done |-> (tap_q == TAP_W'(TAP_MAX)));

endmodule

// File: tb/dqs_tap_sweep_bench.sv
module dqs_test_model (
    input  logic        clk,
    input  logic        clr,
    input  logic        test_req,
    input  logic [5:0]  tap,
    input  int          win_lo,
    input  int          win_hi,
    output logic        test_done,
    output logic [7:0]  fail_cnt,
    output int          runs,
    output int          proto_err,
    output logic [63:0] seen
);
    int lat;

    initial begin
        test_done = 1'b0;
        fail_cnt  = '0;
        runs      = 0;
        proto_err = 0;
        seen      = '0;
        lat       = 0;
        forever begin
            @(posedge clk);
            #1;
            if (clr) begin
                runs = 0;
                seen = '0;
            end
            if (test_done) begin
                test_done = 1'b0;
                lat = 0;
                if (test_req) proto_err++;
            end else if (test_req) begin
                if (lat == 2) begin
                    test_done = 1'b1;
                    runs++;
                    if (seen[tap]) proto_err++;
                    seen[tap] = 1'b1;
                    fail_cnt = (int'(tap) >= win_lo && int'(tap) <= win_hi) ? 8'd0 : 8'd1;
                end else begin
                    lat++;
                end
            end
        end
    end
endmodule

module dqs_tap_sweep_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // default instance
    logic        start_a = 1'b0, wide_a = 1'b0, clr_a = 1'b0;
    logic        req_a, done_a, tdone_a, found_a;
    logic [3:0]  loops_a;
    logic [7:0]  fail_a;
    logic [23:0] lanes_a;
    logic [5:0]  tap_a;
    int          lo_a = 100, hi_a = -1, runs_a, perr_a;
    logic [63:0] seen_a;

    dqs_tap_sweep u_dqs_tap_sweep (
        .clk(clk), .rst(rst), .start(start_a), .wide(wide_a),
        .test_req(req_a), .test_loops(loops_a), .test_done(tdone_a),
        .test_fail_cnt(fail_a), .lane_taps(lanes_a), .cal_done(done_a),
        .cal_found(found_a), .cal_tap(tap_a)
    );

    dqs_test_model u_model_a (
        .clk(clk), .clr(clr_a), .test_req(req_a), .tap(lanes_a[5:0]),
        .win_lo(lo_a), .win_hi(hi_a), .test_done(tdone_a), .fail_cnt(fail_a),
        .runs(runs_a), .proto_err(perr_a), .seen(seen_a)
    );

    // split-chain instance
    logic        start_b = 1'b0, clr_b = 1'b0;
    logic        req_b, done_b, tdone_b, found_b;
    logic [3:0]  loops_b;
    logic [7:0]  fail_b;
    logic [39:0] lanes_b;
    logic [5:0]  tap_b;
    logic [5:0]  dec_b;
    int          lo_b = 100, hi_b = -1, runs_b, perr_b;
    logic [63:0] seen_b;

    dqs_tap_sweep #(.TAP_MAX(62), .SPLIT_CHAIN(1)) u_dqs_tap_sweep_split (
        .clk(clk), .rst(rst), .start(start_b), .wide(1'b1),
        .test_req(req_b), .test_loops(loops_b), .test_done(tdone_b),
        .test_fail_cnt(fail_b), .lane_taps(lanes_b), .cal_done(done_b),
        .cal_found(found_b), .cal_tap(tap_b)
    );

    assign dec_b = (lanes_b[9:5] != 5'd0) ? 6'(lanes_b[9:5]) + 6'd31 : 6'(lanes_b[4:0]);

    dqs_test_model u_model_b (
        .clk(clk), .clr(clr_b), .test_req(req_b), .tap(dec_b),
        .win_lo(lo_b), .win_hi(hi_b), .test_done(tdone_b), .fail_cnt(fail_b),
        .runs(runs_b), .proto_err(perr_b), .seen(seen_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_a(input int lo, input int hi, input logic w);
        int n;
        @(negedge clk);
        lo_a = lo; hi_a = hi; wide_a = w; clr_a = 1'b1;
        @(negedge clk);
        clr_a = 1'b0; start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        n = 0;
        while (!done_a && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk("R8 done seen", int'(done_a), 1);
    endtask

    task automatic run_b(input int lo, input int hi);
        int n;
        @(negedge clk);
        lo_b = lo; hi_b = hi; clr_b = 1'b1;
        @(negedge clk);
        clr_b = 1'b0; start_b = 1'b1;
        @(negedge clk);
        start_b = 1'b0;
        n = 0;
        while (!done_b && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk("R8 split done seen", int'(done_b), 1);
    endtask

    function automatic int lane_a(input int k);
        return int'(lanes_a[k*6 +: 6]);
    endfunction

    task automatic t_reset;
        chk("R9 test_req", int'(req_a), 0);
        chk("R9 cal_done", int'(done_a), 0);
        chk("R9 cal_found", int'(found_a), 0);
        chk("R9 lanes", int'(lanes_a), 0);
        chk("R4 loops", int'(loops_a), 8);
    endtask

    task automatic t_even_window;
        run_a(10, 20, 1'b1);
        chk("R5 centre 10..20", int'(tap_a), 15);
        for (int k = 0; k < 4; k++) chk("R2 wide lane", lane_a(k), 15);
        chk("R1 runs", runs_a, 64);
        chk("R1 every tap", int'(seen_a == '1), 1);
        chk("R8 found", int'(found_a), 1);
        @(negedge clk);
        chk("R8 done one cycle", int'(done_a), 0);
        chk("R3 protocol", perr_a, 0);
    endtask

    task automatic t_roundup_narrow;
        run_a(10, 21, 1'b0);
        chk("R5 round up 10..21", int'(tap_a), 16);
        chk("R2 lane0 narrow", lane_a(0), 16);
        chk("R2 lane1 narrow", lane_a(1), 16);
        chk("R2 lane2 kept", lane_a(2), 15);
        chk("R2 lane3 kept", lane_a(3), 15);
    endtask

    task automatic t_none;
        run_a(100, -1, 1'b1);
        chk("R6 fallback tap", int'(tap_a), 8);
        chk("R6 found low", int'(found_a), 0);
        chk("R6 lane3 fallback", lane_a(3), 8);
        chk("R1 runs none", runs_a, 64);
    endtask

    task automatic t_edges;
        run_a(63, 63, 1'b1);
        chk("R5 top tap only", int'(tap_a), 63);
        run_a(0, 0, 1'b0);
        chk("R5 bottom tap only", int'(tap_a), 0);
        chk("R2 lane0 bottom", lane_a(0), 0);
        chk("R2 lane2 kept top", lane_a(2), 63);
        chk("R3 protocol edges", perr_a, 0);
    endtask

    task automatic t_split;
        run_b(36, 50);
        chk("R7 split tap", int'(tap_b), 43);
        chk("R7 split code", int'(lanes_b[9:0]), (12 << 5) | 11);
        chk("R7 lane3 code", int'(lanes_b[39:30]), (12 << 5) | 11);
        chk("R1 split runs", runs_b, 63);
        chk("R1 split seen", int'(seen_b[62:0] == '1), 1);
        run_b(30, 32);
        chk("R7 at half", int'(lanes_b[9:0]), 31);
        run_b(30, 33);
        chk("R7 above half", int'(lanes_b[9:0]), 32);
        chk("R3 split protocol", perr_b, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_even_window();
        t_roundup_narrow();
        t_none();
        t_edges();
        t_split();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule